// File: doc/BRIEF.md
# Programmable Serial Output Formatter

This block takes one channel's processed result set (I, Q, magnitude, phase, frequency and AGC gain words) and sends a host-programmed series of those words bit-serially, MSB first. It drives a primary data line, an auxiliary data line, a divided serial clock and a frame sync pulse. A one-cycle `res_valid` strobe delivers a result set. The block copies the six words and the sequence configuration at that edge. It then starts the frame at the next serial bit-period boundary.

The serial clock runs all the time at the core clock divided by 1, 2, 4, 8 or 16. Data changes only at the start of a bit period, which is the inactive clock edge. The serial clock rises halfway through the bit period, so the active edge falls in the middle of a stable bit. The sync pulse is one bit period long. It appears either in a lead slot before the first data bit or together with the first data bit. The auxiliary line either repeats the primary word or, in dual mode, carries the next entry in the sequence, which halves the frame length. A result set that arrives while a frame is still in progress is dropped and sets a sticky overflow flag.

The controller is a four-state machine:
- IDLE waits for a result. On `res_valid` (capture) it moves to ALIGN.
- ALIGN waits for the end of the current bit period. At that boundary it moves to LEAD if the lead-sync option is set, and otherwise to SHIFT, loading the first word.
- LEAD sends one sync-only slot and then moves to SHIFT at the next boundary.
- SHIFT sends the words. After the last bit of the last slot it returns to IDLE at the boundary (frame end).

Top module: `serout_fmt`

## Requirements
- R1: The bit period is 2^min(`cfg_div_sel`,4) core cycles, counted from a free-running phase counter that is cleared by reset. Selections 5 to 7 act as 16. For ratios of 2 or more, the serial clock is low in the first half of the bit period and high in the second half. For ratio 1 it is the inverted core clock.
- R2: `cfg_sclk_inv`=1 inverts `sclk` at all times.
- R3: A frame sends entries 0 to `cfg_seq_last` in order. Entry k sits at `cfg_seq[3k+2:3k]`. The codes are 0=I, 1=Q, 2=magnitude, 3=phase, 4=frequency, 5=AGC gain, and 6 or 7 give an all-zero word. Each word is WORD_W bits, sent MSB first, one bit per bit period.
- R4: The first slot of a frame starts at the first bit-period boundary after the capture edge. Outputs change only at bit-period boundaries.
- R5: The sync is active for exactly one bit period per frame. With `cfg_sync_lead`=1 it occupies an extra slot before the first bit, and both data lines are 0 in that slot. With `cfg_sync_lead`=0 it coincides with the first data bit.
- R6: The inactive sync level equals `cfg_sync_inv`, and the active level is its complement.
- R7: With `cfg_dual`=0, `sdata_aux` repeats `sdata_pri`. With `cfg_dual`=1, slot s carries entry 2s on the primary line and entry 2s+1 on the auxiliary line. An auxiliary entry beyond `cfg_seq_last` sends zeros.
- R8: A `res_valid` that arrives while a frame is in progress (ALIGN, LEAD or SHIFT) is dropped. It sets `overflow`, which stays set until reset.
- R9: Words and sequence configuration are sampled at the capture edge. Later changes to them do not affect the frame in progress.
- R10: After reset, both data lines are 0, `sync_out` is at its inactive level and `overflow` is 0.
- R11: In IDLE, between frames, both data lines are 0 and the sync is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | One-cycle strobe that delivers a result set |
| res_i | input | WORD_W | In-phase word |
| res_q | input | WORD_W | Quadrature word |
| res_mag | input | WORD_W | Magnitude word |
| res_phase | input | WORD_W | Phase word |
| res_freq | input | WORD_W | Frequency word |
| res_agc | input | WORD_W | AGC gain word |
| cfg_div_sel | input | 3 | Serial clock ratio selection, as log2 of the ratio |
| cfg_sclk_inv | input | 1 | Inverts the serial clock |
| cfg_sync_inv | input | 1 | Inverts the sync output |
| cfg_sync_lead | input | 1 | 1 = sync in a slot before the first bit |
| cfg_dual | input | 1 | 1 = auxiliary line carries the odd entries |
| cfg_seq_last | input | clog2(SEQ_DEPTH) | Index of the last active sequence entry |
| cfg_seq | input | 3*SEQ_DEPTH | Sequence of 3-bit source codes |
| sclk | output | 1 | Serial clock |
| sdata_pri | output | 1 | Primary serial data |
| sdata_aux | output | 1 | Auxiliary serial data |
| sync_out | output | 1 | Frame sync |
| overflow | output | 1 | Sticky dropped-result flag |

## Verification
The first pattern sends a short unordered sequence at ratio 1. This shows whether the source codes map to the right words and whether the order is kept. A dual-mode frame with an odd entry count, lead sync and both inversions separates the even/odd split and the zero padding from sync placement and polarity. Ratios 16 and the clamped selection 7, run with the zero codes, confirm the bit-period length and zero fill. A frame that is interrupted by a second result, new data and a new sequence shows that overflow is dropped and that the snapshot holds. Every output is compared on every cycle against a queue-based model.

// File: rtl/serout_pkg.sv
`timescale 1ns/1ps
package serout_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        SRC_I     = 3'd0,
        SRC_Q     = 3'd1,
        SRC_MAG   = 3'd2,
        SRC_PHASE = 3'd3,
        SRC_FREQ  = 3'd4,
        SRC_AGC   = 3'd5,
        SRC_ZERO0 = 3'd6,
        SRC_ZERO1 = 3'd7
    } src_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_LEAD,
        ST_SHIFT
    } fmt_state_e;
endpackage

// File: rtl/serout_clkgen.sv
`timescale 1ns/1ps
module serout_clkgen #(
    parameter int MAX_LOG = 4,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             sclk_inv,
    output logic             tick,
    output logic             sclk
);
    logic [MAX_LOG-1:0] phase_q;
    logic [MAX_LOG-1:0] mask;
    logic [SEL_W-1:0]   eff_log;
    logic               base;

    always_comb begin
        eff_log = (div_sel > SEL_W'(MAX_LOG)) ? SEL_W'(MAX_LOG) : div_sel;
    end

    always_comb begin
        mask = '0;
        for (int b = 0; b < MAX_LOG; b++) begin
            mask[b] = (b < int'(eff_log));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    assign tick = ((phase_q & mask) == mask);

    always_comb begin
        if (eff_log == '0) base = ~clk;
        else               base = phase_q[int'(eff_log) - 1];
    end

    assign sclk = base ^ sclk_inv;
endmodule

// File: rtl/serout_seq.sv
`timescale 1ns/1ps
module serout_seq
    import serout_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int SEQ_DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        res_valid,
    input  logic [6*WORD_W-1:0]         res_bank,
    input  logic                        cfg_lead,
    input  logic                        cfg_dual,
    input  logic [$clog2(SEQ_DEPTH)-1:0] cfg_last,
    input  logic [SEQ_DEPTH*CODE_W-1:0] cfg_seq,
    output logic                        sd_pri,
    output logic                        sd_aux,
    output logic                        sync_raw,
    output logic                        overflow
);
    localparam int IDX_W = $clog2(SEQ_DEPTH);
    localparam int CNT_W = $clog2(WORD_W);
    localparam int NSRC  = 6;

    fmt_state_e state, state_n;

    logic [NSRC*WORD_W-1:0]     snap_q;
    logic [SEQ_DEPTH*CODE_W-1:0] seq_q;
    logic [IDX_W-1:0]           last_q;
    logic                       dual_q, lead_q;
    logic [WORD_W-1:0]          sh_pri, sh_aux, ld_pri, ld_aux;
    logic [CNT_W-1:0]           bit_cnt;
    logic [IDX_W-1:0]           slot_idx, nxt_slot, last_slot;
    logic                       sync_q, ovf_q, bit_last, slot_last;
    int                         pe, ae;

    function automatic logic [WORD_W-1:0] pick(input logic [CODE_W-1:0] code,
                                               input logic [NSRC*WORD_W-1:0] bank);
        if (code <= SRC_AGC) return bank[int'(code)*WORD_W +: WORD_W];
        return '0;
    endfunction

    // slot addressing: single mode one entry per slot, dual mode a pair
    always_comb begin
        nxt_slot  = (state == ST_SHIFT) ? slot_idx + 1'b1 : '0;
        last_slot = dual_q ? (last_q >> 1) : last_q;
        pe        = dual_q ? 2 * int'(nxt_slot) : int'(nxt_slot);
        ae        = dual_q ? pe + 1 : pe;
        ld_pri    = (pe <= int'(last_q)) ? pick(seq_q[pe*CODE_W +: CODE_W], snap_q) : '0;
        ld_aux    = (ae <= int'(last_q)) ? pick(seq_q[ae*CODE_W +: CODE_W], snap_q) : '0;
        bit_last  = (bit_cnt == CNT_W'(WORD_W - 1));
        slot_last = (slot_idx == last_slot);
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (res_valid) state_n = ST_ALIGN;
            ST_ALIGN: if (tick)      state_n = lead_q ? ST_LEAD : ST_SHIFT;
            ST_LEAD:  if (tick)      state_n = ST_SHIFT;
            ST_SHIFT: if (tick && bit_last && slot_last) state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q   <= '0;
            seq_q    <= '0;
            last_q   <= '0;
            dual_q   <= 1'b0;
            lead_q   <= 1'b0;
            sh_pri   <= '0;
            sh_aux   <= '0;
            bit_cnt  <= '0;
            slot_idx <= '0;
            sync_q   <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            if (res_valid && state == ST_IDLE) begin
                snap_q <= res_bank;
                seq_q  <= cfg_seq;
                last_q <= cfg_last;
                dual_q <= cfg_dual;
                lead_q <= cfg_lead;
            end
            if (res_valid && state != ST_IDLE) ovf_q <= 1'b1;
            if (tick) begin
                sync_q <= 1'b0;
                case (state)
                    ST_ALIGN: begin
                        sync_q <= 1'b1;
                        if (!lead_q) begin
                            sh_pri   <= ld_pri;
                            sh_aux   <= ld_aux;
                            bit_cnt  <= '0;
                            slot_idx <= nxt_slot;
                        end
                    end
                    ST_LEAD: begin
                        sh_pri   <= ld_pri;
                        sh_aux   <= ld_aux;
                        bit_cnt  <= '0;
                        slot_idx <= nxt_slot;
                    end
                    ST_SHIFT: begin
                        if (bit_last) begin
                            if (!slot_last) begin
                                sh_pri   <= ld_pri;
                                sh_aux   <= ld_aux;
                                bit_cnt  <= '0;
                                slot_idx <= nxt_slot;
                            end
                        end else begin
                            sh_pri  <= sh_pri << 1;
                            sh_aux  <= sh_aux << 1;
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sd_pri   = (state == ST_SHIFT) ? sh_pri[WORD_W-1] : 1'b0;
        sd_aux   = (state == ST_SHIFT) ? sh_aux[WORD_W-1] : 1'b0;
        sync_raw = sync_q;
        overflow = ovf_q;
    end

    // R5: sync lasts a single bit period
    a_r5_sync_one_period: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q && tick) |=> !sync_q);
    // R8: a result during a frame raises the flag
    a_r8_busy_result_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && state != ST_IDLE) |=> ovf_q);
    // R8: flag is sticky
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    // R11: no sync while idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sync_q);
endmodule

// File: rtl/serout_fmt.sv
`timescale 1ns/1ps
module serout_fmt #(
    parameter int WORD_W      = 16,
    parameter int SEQ_DEPTH   = 8,
    parameter int MAX_DIV_LOG = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         res_valid,
    input  logic [WORD_W-1:0]            res_i,
    input  logic [WORD_W-1:0]            res_q,
    input  logic [WORD_W-1:0]            res_mag,
    input  logic [WORD_W-1:0]            res_phase,
    input  logic [WORD_W-1:0]            res_freq,
    input  logic [WORD_W-1:0]            res_agc,
    input  logic [2:0]                   cfg_div_sel,
    input  logic                         cfg_sclk_inv,
    input  logic                         cfg_sync_inv,
    input  logic                         cfg_sync_lead,
    input  logic                         cfg_dual,
    input  logic [$clog2(SEQ_DEPTH)-1:0] cfg_seq_last,
    input  logic [3*SEQ_DEPTH-1:0]       cfg_seq,
    output logic                         sclk,
    output logic                         sdata_pri,
    output logic                         sdata_aux,
    output logic                         sync_out,
    output logic                         overflow
);
    logic tick_w, sd_pri_w, sd_aux_w, sync_w;

    serout_clkgen #(.MAX_LOG(MAX_DIV_LOG), .SEL_W(3)) clkgen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_sel  (cfg_div_sel),
        .sclk_inv (cfg_sclk_inv),
        .tick     (tick_w),
        .sclk     (sclk)
    );

    serout_seq #(.WORD_W(WORD_W), .SEQ_DEPTH(SEQ_DEPTH)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .res_valid (res_valid),
        .res_bank  ({res_agc, res_freq, res_phase, res_mag, res_q, res_i}),
        .cfg_lead  (cfg_sync_lead),
        .cfg_dual  (cfg_dual),
        .cfg_last  (cfg_seq_last),
        .cfg_seq   (cfg_seq),
        .sd_pri    (sd_pri_w),
        .sd_aux    (sd_aux_w),
        .sync_raw  (sync_w),
        .overflow  (overflow)
    );

    assign sdata_pri = sd_pri_w;
    assign sdata_aux = sd_aux_w;
    assign sync_out  = sync_w ^ cfg_sync_inv;

    // R4: data lines move only on bit-period boundaries
    a_r4_pri_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_w |=> $stable(sd_pri_w));
    a_r4_aux_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_w |=> $stable(sd_aux_w));
endmodule

// File: tb/serout_fmt_tb_top.sv
`timescale 1ns/1ps
module serout_fmt_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_i = '0, res_q = '0, res_mag = '0, res_phase = '0, res_freq = '0, res_agc = '0;
    logic [2:0]  cfg_div_sel = '0;
    logic        cfg_sclk_inv = 1'b0, cfg_sync_inv = 1'b0, cfg_sync_lead = 1'b0, cfg_dual = 1'b0;
    logic [2:0]  cfg_seq_last = '0;
    logic [23:0] cfg_seq = '0;
    logic        sclk, sdata_pri, sdata_aux, sync_out, overflow;

    int    n_vec = 0, n_bad = 0;
    string tag = "R10 reset";
    bit    done = 0;

    // reference model state
    int ph = 0;
    bit busy = 0, cur_p = 0, cur_a = 0, cur_s = 0, m_ovf = 0;
    bit qp[$], qa[$], qs[$];

    always #2 clk = ~clk;

    serout_fmt dut_i (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid),
        .res_i(res_i), .res_q(res_q), .res_mag(res_mag), .res_phase(res_phase),
        .res_freq(res_freq), .res_agc(res_agc),
        .cfg_div_sel(cfg_div_sel), .cfg_sclk_inv(cfg_sclk_inv), .cfg_sync_inv(cfg_sync_inv),
        .cfg_sync_lead(cfg_sync_lead), .cfg_dual(cfg_dual), .cfg_seq_last(cfg_seq_last),
        .cfg_seq(cfg_seq), .sclk(sclk), .sdata_pri(sdata_pri), .sdata_aux(sdata_aux),
        .sync_out(sync_out), .overflow(overflow)
    );

    // R3 code map: 0 I, 1 Q, 2 mag, 3 phase, 4 freq, 5 agc, 6/7 zero
    function automatic logic [15:0] word_for(int code);
        case (code)
            0: return res_i;
            1: return res_q;
            2: return res_mag;
            3: return res_phase;
            4: return res_freq;
            5: return res_agc;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic int code_at(int k);
        return int'(cfg_seq[3*k +: 3]);
    endfunction

    task automatic build_frame();
        int cnt, slots;
        cnt   = int'(cfg_seq_last) + 1;
        slots = cfg_dual ? (cnt + 1) / 2 : cnt;
        if (cfg_sync_lead) begin
            qp.push_back(1'b0); qa.push_back(1'b0); qs.push_back(1'b1);
        end
        for (int s = 0; s < slots; s++) begin
            int pidx, aidx;
            logic [15:0] pw, aw;
            pidx = cfg_dual ? 2 * s : s;
            aidx = cfg_dual ? 2 * s + 1 : s;
            pw = word_for(code_at(pidx));
            aw = (aidx < cnt) ? word_for(code_at(aidx)) : 16'h0000;
            for (int b = 15; b >= 0; b--) begin
                qp.push_back(pw[b]);
                qa.push_back(aw[b]);
                qs.push_back(!cfg_sync_lead && s == 0 && b == 15);
            end
        end
    endtask

    function automatic int eff_log();
        return (cfg_div_sel > 3'd4) ? 4 : int'(cfg_div_sel);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; busy = 0; cur_p = 0; cur_a = 0; cur_s = 0; m_ovf = 0;
            qp.delete(); qa.delete(); qs.delete();
        end else begin
            int n;
            bit tk, was_busy;
            n = 1 << eff_log();
            tk = ((ph % n) == n - 1);
            was_busy = busy;
            if (tk && busy) begin
                if (qp.size() > 0) begin
                    cur_p = qp.pop_front(); cur_a = qa.pop_front(); cur_s = qs.pop_front();
                end else begin
                    cur_p = 0; cur_a = 0; cur_s = 0; busy = 0;
                end
            end
            if (res_valid) begin
                if (was_busy) m_ovf = 1;
                else begin build_frame(); busy = 1; end
            end
            ph = (ph + 1) % 16;
        end
    end

    task automatic chk(string req, string what, logic got, logic exp);
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s got %b expected %b at %0t", req, tag, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            int l;
            bit base;
            l = eff_log();
            base = (l == 0) ? 1'b1 : bit'((ph >> (l - 1)) & 1);
            n_vec++;
            chk(cfg_sclk_inv ? "R2" : "R1", "sclk", sclk, base ^ cfg_sclk_inv);
            chk("R3", "sdata_pri", sdata_pri, cur_p);
            chk("R7", "sdata_aux", sdata_aux, cur_a);
            chk(cfg_sync_inv ? "R6" : "R5", "sync_out", sync_out, cur_s ^ cfg_sync_inv);
            chk("R8", "overflow", overflow, m_ovf);
        end
    end

    task automatic pulse_valid();
        @(negedge clk); #0.5 res_valid = 1'b1;
        @(negedge clk); #0.5 res_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic load_words(logic [15:0] base);
        res_i = base ^ 16'h8001; res_q = base ^ 16'h4C32; res_mag = base ^ 16'hA5F0;
        res_phase = base ^ 16'h1E77; res_freq = base ^ 16'hF00D; res_agc = base ^ 16'h3C69;
    endtask

    task automatic setup(logic [2:0] div, bit sinv, bit yinv, bit lead, bit dual,
                         logic [2:0] last, logic [23:0] seq);
        @(negedge clk); #0.5;
        cfg_div_sel = div; cfg_sclk_inv = sinv; cfg_sync_inv = yinv;
        cfg_sync_lead = lead; cfg_dual = dual; cfg_seq_last = last; cfg_seq = seq;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state of the ports
        n_vec++; chk("R10", "sdata_pri", sdata_pri, 1'b0);
        n_vec++; chk("R10", "sdata_aux", sdata_aux, 1'b0);
        n_vec++; chk("R10", "sync_out", sync_out, cfg_sync_inv);
        n_vec++; chk("R10", "overflow", overflow, 1'b0);
        #0.5 rst_n = 1'b1;

        // R3 R4 R11: ratio 1, ordered mag, I, agc
        tag = "R3 R4 R11 ordered at ratio 1";
        setup(3'd0, 0, 0, 0, 0, 3'd2, {15'd0, 3'd5, 3'd0, 3'd2});
        load_words(16'h1234);
        pulse_valid();
        wait_idle();

        // R7 R5 R6 R2: dual, odd count, lead sync, both inversions, ratio 4
        tag = "R7 R5 R6 R2 dual lead inverted";
        setup(3'd2, 1, 1, 1, 1, 3'd4, {9'd0, 3'd0, 3'd6, 3'd4, 3'd3, 3'd1});
        load_words(16'h5A5A);
        pulse_valid();
        wait_idle();

        // R1 R3: clamped ratio selection 7, zero codes
        tag = "R1 R3 clamp and zero codes";
        setup(3'd7, 0, 0, 0, 0, 3'd1, {18'd0, 3'd3, 3'd7});
        load_words(16'h0F0F);
        pulse_valid();
        wait_idle();

        // R8 R9: second result mid-frame with new data and new sequence
        tag = "R8 R9 overflow and snapshot";
        setup(3'd1, 0, 0, 0, 1, 3'd3, {12'd0, 3'd5, 3'd4, 3'd1, 3'd0});
        load_words(16'h7777);
        pulse_valid();
        repeat (12) @(negedge clk);
        #0.5 load_words(16'h0000); cfg_seq = {8{3'd6}}; cfg_dual = 1'b0;
        pulse_valid();
        wait_idle();

        // R3 R5: all eight entries at ratio 8, coincident sync
        tag = "R3 R5 full sequence ratio 8";
        setup(3'd3, 0, 0, 0, 0, 3'd7, {3'd7, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd2});
        load_words(16'hC3A1);
        pulse_valid();
        wait_idle();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog [%s] run did not finish got busy expected done", tag);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule